// File: doc/BRIEF.md
# Monitor Sense Line Sequencer

This block identifies an attached display by probing three open-drain identification wires, called A, B and C. Each wire is pulled up at the connector, and a monitor may ground some of them or tie pairs of them together. When asked to start, the block runs a fixed probe. First it pushes all three wires high for a short settle window. Then it lets go of them and waits a long settle window before it reads their resting levels. After that it pulls one wire low at a time, waits the long window again, and reads the other two wires.

All readings are packed into an 11-bit identification code, and a one-cycle completion pulse marks the end of the probe. The code keeps its value until the next probe writes it. Raw wire levels pass through a two-stage synchroniser inside the block before they are read. For each wire the block gives an output-enable and an output value, so the pad logic can build a tri-state driver. The settle windows are parameters counted in clock cycles. Turning the code into a display timing is the job of the logic that uses it.

Top module: `msense_seq`

## Requirements
- R1: After reset, every output-enable is 0, every output value is 0, the completion pulse is 0 and the code is 0.
- R2: A start request seen while the block is idle begins the probe on the next clock. For exactly SHORT_CYC cycles, all enables read 3'b111 and all values read 3'b111. Enable and value bit 0 is wire A, bit 1 is B and bit 2 is C. No value bit is ever 1 outside this window.
- R3: Next, all enables are 0 for exactly LONG_CYC cycles. At the end of this window, the synchronised levels of A, B and C are stored into code bits 10, 9 and 8 respectively.
- R4: Next, only A is enabled, with value 0, for LONG_CYC cycles. At the end of this window, B is stored into code bit 5 and C into code bit 4.
- R5: Next, only B is enabled, with value 0, for LONG_CYC cycles. At the end of this window, A is stored into code bit 3 and C into code bit 2.
- R6: Next, only C is enabled, with value 0, for LONG_CYC cycles. At the end of this window, A is stored into code bit 1 and B into code bit 0.
- R7: In the cycle right after the C-low window, the completion pulse is 1 for exactly one cycle with all enables 0. After that the block stays idle with all enables 0.
- R8: Code bits 7 and 6 are always 0.
- R9: A start request raised while a probe is in progress has no effect. A start request raised during the completion cycle begins a new probe on the next clock.
- R10: Between the end of one probe and the start of the next, the code does not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted synchronously upstream |
| start_i | input | 1 | Probe request, sampled on each rising edge |
| line_i | input | 3 | Raw wire levels, bit 0 = A, bit 1 = B, bit 2 = C |
| drv_en_o | output | 3 | Per-wire output-enable for the tri-state pad |
| drv_val_o | output | 3 | Per-wire driven level, meaningful when enabled |
| done_o | output | 1 | One-cycle pulse when the code is complete |
| code_o | output | 11 | Packed identification code |

## Verification
Some properties are checked by assertions on every clock:
- Active-high drive only happens with all three wires enabled at once.
- At most one wire is ever pulled low.
- The completion pulse lasts one cycle and occurs with the drivers off.
- Code bits 7:6 stay clear, and the code is frozen while idle.
- A checker counter measures each driven window and compares its length with the parameters.

Other behaviour can only be shown by the bench's scenarios, because it depends on a modelled monitor whose grounded and bridged wires give known readings:
- Each reading lands in its assigned code bit.
- The synchroniser delay does not corrupt a sample.
- Start requests raised mid-probe are ignored.
- A start request raised in the completion cycle is accepted.

// File: rtl/msense_pkg.sv
package msense_pkg;
  localparam int unsigned NUM_LINES = 3;
  localparam int unsigned CODE_W    = 11;
  localparam int unsigned LN_A      = 0;
  localparam int unsigned LN_B      = 1;
  localparam int unsigned LN_C      = 2;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_HIGH = 3'd1,
    ST_REL  = 3'd2,
    ST_LOWA = 3'd3,
    ST_LOWB = 3'd4,
    ST_LOWC = 3'd5,
    ST_DONE = 3'd6
  } msense_state_e;
endpackage

// File: rtl/msense_sync.sv
module msense_sync #(
  parameter int unsigned WIDTH  = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    logic [STAGES-1:0] chain_q;
    logic [STAGES-1:0] chain_d;

    always_comb begin
      chain_d = {chain_q[STAGES-2:0], async_i[g]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= chain_d;
    end

    assign sync_o[g] = chain_q[STAGES-1];
  end
endmodule

// File: rtl/msense_timer.sv
module msense_timer #(
  parameter int unsigned SHORT_CYC = 200,
  parameter int unsigned LONG_CYC  = 2000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart_i,
  input  logic run_i,
  input  logic sel_short_i,
  output logic expire_o
);
  localparam int unsigned MAX_CYC = (SHORT_CYC > LONG_CYC) ? SHORT_CYC : LONG_CYC;
  localparam int unsigned CNT_W   = $clog2(MAX_CYC + 1);
  localparam logic [CNT_W-1:0] SHORT_LAST = CNT_W'(SHORT_CYC - 1);
  localparam logic [CNT_W-1:0] LONG_LAST  = CNT_W'(LONG_CYC - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;
  logic [CNT_W-1:0] last;

  always_comb begin
    last   = sel_short_i ? SHORT_LAST : LONG_LAST;
    cnt_en = restart_i | run_i;
    cnt_d  = restart_i ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign expire_o = run_i & (cnt_q == last);
endmodule

// File: rtl/msense_fsm.sv
module msense_fsm
  import msense_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start_i,
  input  logic                 expire_i,
  input  logic [NUM_LINES-1:0] lines_i,
  output logic                 run_o,
  output logic                 restart_o,
  output logic                 sel_short_o,
  output logic                 busy_o,
  output logic [NUM_LINES-1:0] drv_en_o,
  output logic [NUM_LINES-1:0] drv_val_o,
  output logic                 done_o,
  output logic [CODE_W-1:0]    code_o
);
  msense_state_e     state_q, state_d;
  logic [CODE_W-1:0] code_q, code_d;
  logic              code_en;
  logic              accept;

  always_comb begin
    accept  = start_i & ((state_q == ST_IDLE) | (state_q == ST_DONE));
    state_d = state_q;
    code_d  = code_q;
    code_en = 1'b0;
    unique case (state_q)
      ST_IDLE: if (accept) state_d = ST_HIGH;
      ST_HIGH: if (expire_i) state_d = ST_REL;
      ST_REL: if (expire_i) begin
        state_d    = ST_LOWA;
        code_en    = 1'b1;
        code_d[10] = lines_i[LN_A];
        code_d[9]  = lines_i[LN_B];
        code_d[8]  = lines_i[LN_C];
      end
      ST_LOWA: if (expire_i) begin
        state_d   = ST_LOWB;
        code_en   = 1'b1;
        code_d[5] = lines_i[LN_B];
        code_d[4] = lines_i[LN_C];
      end
      ST_LOWB: if (expire_i) begin
        state_d   = ST_LOWC;
        code_en   = 1'b1;
        code_d[3] = lines_i[LN_A];
        code_d[2] = lines_i[LN_C];
      end
      ST_LOWC: if (expire_i) begin
        state_d   = ST_DONE;
        code_en   = 1'b1;
        code_d[1] = lines_i[LN_A];
        code_d[0] = lines_i[LN_B];
      end
      ST_DONE: state_d = accept ? ST_HIGH : ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
    code_d[7:6] = 2'b00;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       code_q <= '0;
    else if (code_en) code_q <= code_d;
  end

  always_comb begin
    drv_en_o  = '0;
    drv_val_o = '0;
    unique case (state_q)
      ST_HIGH: begin drv_en_o = '1; drv_val_o = '1; end
      ST_LOWA: drv_en_o[LN_A] = 1'b1;
      ST_LOWB: drv_en_o[LN_B] = 1'b1;
      ST_LOWC: drv_en_o[LN_C] = 1'b1;
      default: ;
    endcase
  end

  assign busy_o      = (state_q != ST_IDLE) & (state_q != ST_DONE);
  assign run_o       = busy_o;
  assign restart_o   = accept | expire_i;
  assign sel_short_o = (state_q == ST_HIGH);
  assign done_o      = (state_q == ST_DONE);
  assign code_o      = code_q;
endmodule

// File: rtl/msense_seq.sv
module msense_seq
  import msense_pkg::*;
#(
  parameter int unsigned SHORT_CYC   = 200,
  parameter int unsigned LONG_CYC    = 2000,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start_i,
  input  logic [NUM_LINES-1:0] line_i,
  output logic [NUM_LINES-1:0] drv_en_o,
  output logic [NUM_LINES-1:0] drv_val_o,
  output logic                 done_o,
  output logic [CODE_W-1:0]    code_o
);
  logic [NUM_LINES-1:0] line_sync;
  logic                 run, restart, sel_short, expire, busy;

  msense_sync #(.WIDTH(NUM_LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (line_i),
    .sync_o  (line_sync)
  );

  msense_timer #(.SHORT_CYC(SHORT_CYC), .LONG_CYC(LONG_CYC)) u_timer (
    .clk         (clk),
    .rst_n       (rst_n),
    .restart_i   (restart),
    .run_i       (run),
    .sel_short_i (sel_short),
    .expire_o    (expire)
  );

  msense_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .expire_i    (expire),
    .lines_i     (line_sync),
    .run_o       (run),
    .restart_o   (restart),
    .sel_short_o (sel_short),
    .busy_o      (busy),
    .drv_en_o    (drv_en_o),
    .drv_val_o   (drv_val_o),
    .done_o      (done_o),
    .code_o      (code_o)
  );
endmodule

// File: rtl/msense_seq_chk.sv
module msense_seq_chk #(
  parameter int unsigned SHORT_CYC = 200,
  parameter int unsigned LONG_CYC  = 2000
) (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic [2:0]  drv_en_o,
  input logic [2:0]  drv_val_o,
  input logic        done_o,
  input logic [10:0] code_o
);
  logic [5:0]  prev_pat;
  logic [31:0] run_len;
  logic [5:0]  cur_pat;

  assign cur_pat = {drv_en_o, drv_val_o};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_pat <= '0;
      run_len  <= '0;
    end else begin
      prev_pat <= cur_pat;
      run_len  <= (cur_pat != prev_pat) ? 32'd1 : run_len + 32'd1;
    end
  end

  p_high_all_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (drv_val_o != 3'b000) |-> (drv_en_o == 3'b111 && drv_val_o == 3'b111));

  p_high_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_pat != prev_pat && prev_pat == 6'b111111) |-> (run_len == 32'(SHORT_CYC)));

  p_low_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_pat != prev_pat && prev_pat[2:0] == 3'b000 && prev_pat[5:3] != 3'b000)
      |-> (run_len == 32'(LONG_CYC)));

  p_one_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(drv_en_o & ~drv_val_o));

  p_done_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (drv_en_o == 3'b000));

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  p_gap_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    code_o[7:6] == 2'b00);

  p_code_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> $stable(code_o));
endmodule

bind msense_seq msense_seq_chk #(.SHORT_CYC(SHORT_CYC), .LONG_CYC(LONG_CYC)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .busy      (busy),
  .drv_en_o  (drv_en_o),
  .drv_val_o (drv_val_o),
  .done_o    (done_o),
  .code_o    (code_o)
);

// File: tb/msense_seq_bench.sv
module msense_seq_bench;
  localparam int SH = 5;
  localparam int LG = 12;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [2:0]  line_i;
  logic [2:0]  drv_en_o, drv_val_o;
  logic        done_o;
  logic [10:0] code_o;

  logic [2:0] idle_lvl = 3'b111;
  logic       link_ab = 1'b0, link_ac = 1'b0, link_bc = 1'b0;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  bit ran_once = 0;

  logic [6:0]  exp_q[$];
  logic [10:0] exp_code = '0;
  logic [10:0] pend_code = '0;

  always #10 clk = ~clk;

  msense_seq #(.SHORT_CYC(SH), .LONG_CYC(LG)) u_msense_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .line_i(line_i),
    .drv_en_o(drv_en_o), .drv_val_o(drv_val_o), .done_o(done_o), .code_o(code_o)
  );

  function automatic logic linked(int x, int y);
    if ((x == 0 && y == 1) || (x == 1 && y == 0)) return link_ab;
    if ((x == 0 && y == 2) || (x == 2 && y == 0)) return link_ac;
    if ((x == 1 && y == 2) || (x == 2 && y == 1)) return link_bc;
    return 1'b0;
  endfunction

  function automatic logic [2:0] wire_lvl(logic [2:0] en, logic [2:0] val);
    logic [2:0] r;
    for (int x = 0; x < 3; x++) begin
      if (en[x]) r[x] = val[x];
      else begin
        r[x] = idle_lvl[x];
        for (int y = 0; y < 3; y++)
          if (y != x && en[y] && !val[y] && linked(x, y)) r[x] = 1'b0;
      end
    end
    return r;
  endfunction

  assign line_i = wire_lvl(drv_en_o, drv_val_o);

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", req, act, exp, cycles);
    end
  endtask

  function automatic string drv_tag(logic [6:0] e, bit idle);
    if (idle) return ran_once ? "R7" : "R1";
    if (e[6]) return "R7";
    if (e[2:0] == 3'b111) return "R2";
    case (e[5:3])
      3'b000: return "R3";
      3'b001: return "R4";
      3'b010: return "R5";
      default: return "R6";
    endcase
  endfunction

  always @(negedge clk) begin
    if (rst_n) begin
      logic [6:0] e;
      bit idle;
      cycles++;
      idle = (exp_q.size() == 0);
      e = idle ? 7'd0 : exp_q.pop_front();
      check({drv_tag(e, idle), " enables"}, drv_en_o, e[5:3]);
      check({drv_tag(e, idle), " values"}, drv_val_o, e[2:0]);
      check({drv_tag(e, idle), " done"}, done_o, e[6]);
      if (e[6]) begin
        exp_code = pend_code;
        ran_once = 1;
        check("R3 code[10:8]", code_o[10:8], exp_code[10:8]);
        check("R4 code[5:4]", code_o[5:4], exp_code[5:4]);
        check("R5 code[3:2]", code_o[3:2], exp_code[3:2]);
        check("R6 code[1:0]", code_o[1:0], exp_code[1:0]);
        check("R8 code[7:6]", code_o[7:6], 0);
      end else if (idle) begin
        check(ran_once ? "R10 held code" : "R1 reset code", code_o, exp_code);
      end
      if (start_i && exp_q.size() == 0) begin
        logic [2:0] r0, ra, rb, rc;
        r0 = wire_lvl(3'b000, 3'b000);
        ra = wire_lvl(3'b001, 3'b000);
        rb = wire_lvl(3'b010, 3'b000);
        rc = wire_lvl(3'b100, 3'b000);
        pend_code = {r0[0], r0[1], r0[2], 2'b00, ra[1], ra[2], rb[0], rb[2], rc[0], rc[1]};
        for (int i = 0; i < SH; i++) exp_q.push_back({1'b0, 3'b111, 3'b111});
        for (int i = 0; i < LG; i++) exp_q.push_back({1'b0, 3'b000, 3'b000});
        for (int i = 0; i < LG; i++) exp_q.push_back({1'b0, 3'b001, 3'b000});
        for (int i = 0; i < LG; i++) exp_q.push_back({1'b0, 3'b010, 3'b000});
        for (int i = 0; i < LG; i++) exp_q.push_back({1'b0, 3'b100, 3'b000});
        exp_q.push_back({1'b1, 3'b000, 3'b000});
      end
    end
  end

  task automatic tick(int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #2;
    end
  endtask

  task automatic pulse_start();
    start_i = 1'b1;
    tick(1);
    start_i = 1'b0;
  endtask

  task automatic wait_done();
    for (int i = 0; i < 2000; i++) begin
      tick(1);
      if (done_o) break;
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    for (int i = 0; i < 100000; i++) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    tick(3);
    #5 rst_n = 1'b1;
    tick(5);
    // R1: idle after reset, checked per cycle
    idle_lvl = 3'b111; link_ab = 0; link_ac = 0; link_bc = 0;
    pulse_start();                      // R2 R3 R4 R5 R6 R7
    wait_done();
    tick(6);                            // R10
    idle_lvl = 3'b101; link_ac = 1;
    pulse_start();
    tick(10);
    pulse_start();                      // R9: ignored mid-run
    tick(20);
    pulse_start();                      // R9
    wait_done();
    tick(4);
    idle_lvl = 3'b110; link_ac = 0; link_bc = 1; link_ab = 1;
    pulse_start();
    wait_done();
    pulse_start();                      // R9: start in completion cycle
    idle_lvl = 3'b110;
    wait_done();
    tick(5);
    idle_lvl = 3'b011; link_ab = 0; link_bc = 0; link_ac = 0;
    pulse_start();
    wait_done();
    tick(8);
    finish_run();
  end
endmodule